// File: doc/BRIEF.md
# Pipelined Binary32 Adder/Subtractor with Flush-to-Zero

This block adds or subtracts two IEEE 754 binary32 operands in a fixed three-stage pipeline. Each operation carries its own operation select (add, or subtract the second operand from the first) and its own rounding select, so neighbouring operations in the pipeline may use different settings. One operation may enter on every clock cycle. A valid strobe travels alongside the data and marks the cycle in which the matching result sits on the output.

Subnormal numbers are not supported as values. An input whose exponent field is zero counts as a zero that keeps its sign bit. A result whose magnitude would fall below the smallest normal number becomes a zero with the sign of the exact result. NaN and infinity operands follow the usual rules, and every NaN produced is the canonical quiet pattern. The block reports no exception flags. It sits in a larger arithmetic pipeline, and its result feeds the next stage directly.

Top module: `fp32_addsub_ftz`

## Requirements
- R1: With `subOp`=0 the result is opA+opB, and with `subOp`=1 it is opA−opB. When `roundSel`=0 the result is the exact value rounded to the nearest binary32 number.
- R2: With `roundSel`=1 the exact value is truncated toward zero.
- R3: When `roundSel`=0 and the exact value lies exactly halfway between two representable numbers, the result is the one whose significand LSB is 0.
- R4: An operand with exponent field 0 is treated as a zero carrying that operand's sign bit, whatever its fraction bits hold.
- R5: A finite nonzero exact result with magnitude below 2^-126 is returned as a zero (exponent and fraction all zero) with the sign of the exact result. No output ever has exponent 0 and a nonzero fraction.
- R6: If either operand is a NaN (exponent 255, nonzero fraction), the result is 0x7FC00000.
- R7: If two infinities of opposite effective sign meet (for example +inf − +inf), the result is 0x7FC00000. Otherwise an infinite operand gives an infinity of its effective sign.
- R8: If the rounded magnitude reaches 2^128, the result is ±infinity (0x7F800000 with the sign) when `roundSel`=0, and ±0x7F7FFFFF when `roundSel`=1.
- R9: An exact zero sum gives +0 under both rounding selects. The one exception is when both operands are zeros of effective sign negative: the result is then 0x80000000.
- R10: An operation presented with `inValid` high in cycle n appears on `result`, with `outValid` high, in cycle n+3. One operation is accepted per cycle, and `outValid` is high only for accepted operations.
- R11: While and after reset, `outValid` is 0 and `result` is 0 until the first operation arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present on the inputs this cycle |
| opA | input | 32 | First operand, binary32 |
| opB | input | 32 | Second operand, binary32 |
| subOp | input | 1 | 0 = add, 1 = subtract opB from opA |
| roundSel | input | 1 | 0 = nearest, ties to even; 1 = toward zero |
| outValid | output | 1 | Result valid this cycle |
| result | output | 32 | Binary32 result |

## Verification
The bench targets several corner cases, and each one exposes a specific design error:
- Halfway ties with both even and odd significands: a design that rounds ties away from zero returns an odd significand.
- Differences of two nearly equal numbers that land below the normal range: a design that keeps subnormals returns a nonzero tiny pattern, and one that loses the sign returns +0 where −0 is due.
- Large-operand sums that overflow under each rounding select: a design that ignores the select saturates or overflows the wrong way.
- Zero results built from every sign combination, including flushed subnormal inputs, so that a wrong zero sign is caught.
- NaN and infinity mixes, which catch a design that propagates a NaN payload or lets inf−inf through.
- Random traffic with idle gaps, which catches any drift in the three-cycle latency.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int GRS_W   = 3;
  localparam int EXT_W   = SIG_W + GRS_W;
  localparam int SUM_W   = EXT_W + 1;
  localparam int ALIGN_W = SIG_W + EXT_W - 1;
  localparam int LZ_W    = $clog2(EXT_W + 1);
  localparam int SEXP_W  = EXP_W + 2;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  localparam logic [WORD_W-2:0] INF_MAG  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-2:0] MAXF_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  localparam logic [WORD_W-1:0] QNAN     = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic {RM_NEAREST = 1'b0, RM_TOZERO = 1'b1} roundMode_e;

  typedef struct packed {
    logic ldUnpack;
    logic ldAlign;
    logic ldRound;
  } stageStrobes_t;

  function automatic logic [LZ_W-1:0] leadZeros(input logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] cnt;
    logic found;
    cnt = '0;
    found = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (v[i]) found = 1'b1;
        else cnt = cnt + 1'b1;
      end
    end
    return cnt;
  endfunction
endpackage

// File: rtl/fpaddCtrl.sv
module fpaddCtrl
  import fpadd_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output stageStrobes_t strobe,
  output logic          outValid
);
  logic v1, v2, v3;
  logic [1:0] rstAge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      rstAge <= '0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
      if (rstAge != 2'd3) rstAge <= rstAge + 2'd1;
    end
  end

  always_comb begin
    strobe.ldUnpack = inValid;
    strobe.ldAlign  = v1;
    strobe.ldRound  = v2;
  end

  assign outValid = v3;

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstAge == 2'd3) |-> (outValid == $past(inValid, 3)));
endmodule

// File: rtl/fpaddDatapath.sv
module fpaddDatapath
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobes_t     strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subOp,
  input  logic              roundSel,
  output logic [WORD_W-1:0] result
);
  // ---------------- stage 1: classify, order by magnitude ----------------
  logic signA, signB, nanA, nanB, infA, infB, zeroA, zeroB, aBig;
  logic [WORD_W-2:0] magA, magB, magBig, magSmall;
  logic specialHit;
  logic [WORD_W-1:0] specialWord;

  assign signA = opA[WORD_W-1];
  assign signB = opB[WORD_W-1] ^ subOp;
  assign zeroA = (opA[WORD_W-2:FRAC_W] == '0);
  assign zeroB = (opB[WORD_W-2:FRAC_W] == '0);
  assign nanA  = (opA[WORD_W-2:FRAC_W] == EXP_W'(EXP_MAX)) && (opA[FRAC_W-1:0] != '0);
  assign nanB  = (opB[WORD_W-2:FRAC_W] == EXP_W'(EXP_MAX)) && (opB[FRAC_W-1:0] != '0);
  assign infA  = (opA[WORD_W-2:0] == INF_MAG);
  assign infB  = (opB[WORD_W-2:0] == INF_MAG);
  assign magA  = zeroA ? '0 : opA[WORD_W-2:0];
  assign magB  = zeroB ? '0 : opB[WORD_W-2:0];
  assign aBig  = (magA >= magB);
  assign magBig   = aBig ? magA : magB;
  assign magSmall = aBig ? magB : magA;

  always_comb begin
    specialHit  = 1'b1;
    specialWord = '0;
    if (nanA || nanB)       specialWord = QNAN;
    else if (infA && infB)  specialWord = (signA == signB) ? {signA, INF_MAG} : QNAN;
    else if (infA)          specialWord = {signA, INF_MAG};
    else if (infB)          specialWord = {signB, INF_MAG};
    else if (zeroA && zeroB) specialWord = {signA & signB, {(WORD_W-1){1'b0}}};
    else                    specialHit = 1'b0;
  end

  logic s1Special, s1Sign, s1EffSub;
  logic [WORD_W-1:0] s1SpecialWord;
  logic [EXP_W-1:0] s1Exp, s1Diff;
  logic [SIG_W-1:0] s1BigSig, s1SmallSig;
  roundMode_e s1Rm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Special <= 1'b0; s1SpecialWord <= '0; s1Sign <= 1'b0; s1EffSub <= 1'b0;
      s1Exp <= '0; s1Diff <= '0; s1BigSig <= '0; s1SmallSig <= '0; s1Rm <= RM_NEAREST;
    end else if (strobe.ldUnpack) begin
      s1Special     <= specialHit;
      s1SpecialWord <= specialWord;
      s1Sign        <= aBig ? signA : signB;
      s1EffSub      <= signA ^ signB;
      s1Exp         <= magBig[WORD_W-2:FRAC_W];
      s1Diff        <= magBig[WORD_W-2:FRAC_W] - magSmall[WORD_W-2:FRAC_W];
      s1BigSig      <= {1'b1, magBig[FRAC_W-1:0]};
      s1SmallSig    <= (magSmall[WORD_W-2:FRAC_W] == '0) ? '0 : {1'b1, magSmall[FRAC_W-1:0]};
      s1Rm          <= roundMode_e'(roundSel);
    end
  end

  // ---------------- stage 2: align and add ----------------
  logic [ALIGN_W-1:0] shifted;
  logic [EXT_W-1:0] alignedSmall;
  logic [SUM_W-1:0] bigExt, smallExt, sumNext;

  always_comb begin
    shifted = {s1SmallSig, {(EXT_W-1){1'b0}}} >> s1Diff;
    if (s1Diff > EXP_W'(EXT_W - 1))
      alignedSmall = {{(EXT_W-1){1'b0}}, |s1SmallSig};
    else
      alignedSmall = shifted[ALIGN_W-1 -: EXT_W]
                   | {{(EXT_W-1){1'b0}}, |shifted[ALIGN_W-EXT_W-1:0]};
    bigExt   = {1'b0, s1BigSig, {GRS_W{1'b0}}};
    smallExt = {1'b0, alignedSmall};
    sumNext  = s1EffSub ? (bigExt - smallExt) : (bigExt + smallExt);
  end

  logic s2Special, s2Sign;
  logic [WORD_W-1:0] s2SpecialWord;
  logic [EXP_W-1:0] s2Exp;
  logic [SUM_W-1:0] s2Sum;
  roundMode_e s2Rm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Special <= 1'b0; s2SpecialWord <= '0; s2Sign <= 1'b0;
      s2Exp <= '0; s2Sum <= '0; s2Rm <= RM_NEAREST;
    end else if (strobe.ldAlign) begin
      s2Special     <= s1Special;
      s2SpecialWord <= s1SpecialWord;
      s2Sign        <= s1Sign;
      s2Exp         <= s1Exp;
      s2Sum         <= sumNext;
      s2Rm          <= s1Rm;
    end
  end

  // R1: the larger operand comes first, so a subtraction never carries out
  sub_no_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldAlign && s1EffSub && !s1Special) |=> !s2Sum[SUM_W-1]);

  // ---------------- stage 3: normalize, round, pack ----------------
  logic [LZ_W-1:0] lz;
  logic [EXT_W-1:0] normSig;
  logic [SEXP_W-1:0] normExp, finalExp;
  logic [SIG_W:0] rounded;
  logic roundUp;
  logic [FRAC_W-1:0] finalFrac;
  logic [WORD_W-1:0] resultNext;

  always_comb begin
    lz = leadZeros(s2Sum[EXT_W-1:0]);
    if (s2Sum[SUM_W-1]) begin
      normSig = {s2Sum[SUM_W-1:2], s2Sum[1] | s2Sum[0]};
      normExp = {2'b00, s2Exp} + SEXP_W'(1);
    end else begin
      normSig = s2Sum[EXT_W-1:0] << lz;
      normExp = {2'b00, s2Exp} - {{(SEXP_W-LZ_W){1'b0}}, lz};
    end
    roundUp = (s2Rm == RM_NEAREST) && normSig[GRS_W-1]
            && ((|normSig[GRS_W-2:0]) || normSig[GRS_W]);
    rounded = {1'b0, normSig[EXT_W-1:GRS_W]} + {{SIG_W{1'b0}}, roundUp};
    if (rounded[SIG_W]) begin
      finalExp  = normExp + SEXP_W'(1);
      finalFrac = rounded[SIG_W-1:1];
    end else begin
      finalExp  = normExp;
      finalFrac = rounded[FRAC_W-1:0];
    end

    if (s2Special)
      resultNext = s2SpecialWord;
    else if (s2Sum == '0)
      resultNext = '0;
    else if (normExp[SEXP_W-1] || (normExp == '0))
      resultNext = {s2Sign, {(WORD_W-1){1'b0}}};
    else if (finalExp >= SEXP_W'(EXP_MAX))
      resultNext = {s2Sign, (s2Rm == RM_NEAREST) ? INF_MAG : MAXF_MAG};
    else
      resultNext = {s2Sign, finalExp[EXP_W-1:0], finalFrac};
  end

  always_ff @(posedge clk) begin
    if (!rstN) result <= '0;
    else if (strobe.ldRound) result <= resultNext;
  end

  // R5
  no_subnormal_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((result[WORD_W-2:FRAC_W] == '0) && (result[FRAC_W-1:0] != '0)));

  // R6
  canonical_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((result[WORD_W-2:FRAC_W] == EXP_W'(EXP_MAX)) && (result[FRAC_W-1:0] != '0))
      |-> (result == QNAN));

  // R8
  rtz_no_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldRound && !s2Special && (s2Rm == RM_TOZERO))
      |=> (result[WORD_W-2:0] != INF_MAG));
endmodule

// File: rtl/fp32_addsub_ftz.sv
module fp32_addsub_ftz
  import fpadd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        subOp,
  input  logic        roundSel,
  output logic        outValid,
  output logic [31:0] result
);
  stageStrobes_t strobe;

  fpaddCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fpaddDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .subOp    (subOp),
    .roundSel (roundSel),
    .result   (result)
  );

  // R11
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!rstN) && !inValid) |=> !outValid);
endmodule

// File: tb/tb_fp32_addsub_ftz.sv
`timescale 1ns/1ps
module tb_fp32_addsub_ftz;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic subOp = 1'b0, roundSel = 1'b0;
  logic outValid;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string tagQ[$];
  int cycQ[$];

  always #5 clk = ~clk;

  fp32_addsub_ftz dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .subOp(subOp), .roundSel(roundSel), .outValid(outValid), .result(result)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Exact reference: both operands as integers in units of 2^-149
  function automatic logic [31:0] refAdd(input logic [31:0] a, input logic [31:0] b,
                                         input logic op, input logic rm);
    logic sa, sb, sr, zA, zB, nA, nB, iA, iB, g, st, inc;
    logic [299:0] ma, mb, mag;
    logic [24:0] keep;
    int p, sh, e;
    sa = a[31];
    sb = b[31] ^ op;
    zA = (a[30:23] == 8'd0);
    zB = (b[30:23] == 8'd0);
    nA = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nB = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    iA = (a[30:0] == 31'h7F800000);
    iB = (b[30:0] == 31'h7F800000);
    if (nA || nB) return 32'h7FC00000;
    if (iA && iB) return (sa == sb) ? {sa, 31'h7F800000} : 32'h7FC00000;
    if (iA) return {sa, 31'h7F800000};
    if (iB) return {sb, 31'h7F800000};
    ma = zA ? 300'd0 : (300'({1'b1, a[22:0]}) << (a[30:23] - 1));
    mb = zB ? 300'd0 : (300'({1'b1, b[22:0]}) << (b[30:23] - 1));
    if (sa == sb) begin mag = ma + mb; sr = sa; end
    else if (ma >= mb) begin mag = ma - mb; sr = sa; end
    else begin mag = mb - ma; sr = sb; end
    if (mag == 0) return {sa & sb, 31'd0};
    p = -1;
    for (int i = 0; i < 300; i++) if (mag[i]) p = i;
    if (p < 23) return {sr, 31'd0};
    sh = p - 23;
    keep = 25'(mag >> sh);
    g  = (sh > 0) ? mag[sh-1] : 1'b0;
    st = (sh > 1) ? ((mag & ((300'd1 << (sh - 1)) - 300'd1)) != 0) : 1'b0;
    inc = !rm && g && (st || keep[0]);
    keep = keep + 25'(inc);
    e = p - 22;
    if (keep[24]) begin keep = keep >> 1; e = e + 1; end
    if (e >= 255) return rm ? {sr, 31'h7F7FFFFF} : {sr, 31'h7F800000};
    return {sr, 8'(e), keep[22:0]};
  endfunction

  function automatic logic [31:0] pickOperand(input logic [31:0] other);
    int k;
    logic [31:0] w;
    k = $urandom_range(0, 99);
    w = $urandom;
    if (k < 45)      w[30:23] = 8'($urandom_range(118, 136));
    else if (k < 55) w[30:23] = 8'($urandom_range(248, 254));
    else if (k < 65) w[30:23] = 8'($urandom_range(1, 4));
    else if (k < 75) w = other ^ ($urandom & 32'h000000FF);
    else if (k < 80) w[30:23] = 8'd0;
    else if (k < 83) w[30:0] = 31'h7F800000;
    else if (k < 85) w[30:23] = 8'hFF;
    return w;
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic op,
                      input logic rm, input string tag);
    @(negedge clk);
    opA = a; opB = b; subOp = op; roundSel = rm; inValid = 1'b1;
    expQ.push_back(refAdd(a, b, op, rm));
    tagQ.push_back(tag);
    cycQ.push_back(cyc);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      if (rstN) begin
        if (outValid) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R10 unexpected outValid", result, 32'h0);
          end else begin
            logic [31:0] e;
            string t;
            int c;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            c = cycQ.pop_front();
            check(result === e, t, result, e);
            check(cyc == c + 3, "R10 latency", 32'(cyc - c), 32'(3));
          end
        end else if (cycQ.size() != 0 && cyc >= cycQ[0] + 3) begin
          check(1'b0, "R10 missing outValid", 32'(cyc), 32'(cycQ[0] + 3));
          void'(expQ.pop_front()); void'(tagQ.pop_front()); void'(cycQ.pop_front());
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R11 outValid in reset", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(outValid === 1'b0, "R11 outValid after reset", {31'd0, outValid}, 32'd0);
    check(result === 32'h0, "R11 result after reset", result, 32'h0);

    // directed corners, issued back to back
    send(32'h3F800000, 32'h3F800000, 1'b0, 1'b0, "R1 1+1");
    send(32'h3F800000, 32'h3F000000, 1'b1, 1'b0, "R1 1-0.5");
    check(refAdd(32'h3F800000, 32'h3F000000, 1'b1, 1'b0) == 32'h3F000000, "R1 model", 32'h0, 32'h3F000000);
    send(32'h3F800000, 32'h33800000, 1'b0, 1'b0, "R3 tie even down");
    send(32'h3F800001, 32'h33800000, 1'b0, 1'b0, "R3 tie odd up");
    check(refAdd(32'h3F800001, 32'h33800000, 1'b0, 1'b0) == 32'h3F800002, "R3 model", 32'h0, 32'h3F800002);
    send(32'h3F800000, 32'h33FFFFFF, 1'b0, 1'b1, "R2 truncate");
    send(32'h3F800000, 32'h33FFFFFF, 1'b0, 1'b0, "R1 nearest up");
    send(32'hBF800000, 32'hB3FFFFFF, 1'b0, 1'b1, "R2 truncate neg");
    send(32'h00000001, 32'h3F800000, 1'b0, 1'b0, "R4 subnormal in");
    send(32'h807FFFFF, 32'h00000000, 1'b0, 1'b0, "R4 -sub + +0");
    send(32'h80000005, 32'h80000000, 1'b0, 1'b0, "R4 -sub + -0");
    send(32'h00800001, 32'h00800000, 1'b1, 1'b0, "R5 flush pos");
    send(32'h00800000, 32'h00800001, 1'b1, 1'b1, "R5 flush neg");
    send(32'h7FC12345, 32'h3F800000, 1'b0, 1'b0, "R6 qnan");
    send(32'h3F800000, 32'hFF800001, 1'b1, 1'b1, "R6 snan");
    send(32'h7F800000, 32'h7F800000, 1'b1, 1'b0, "R7 inf-inf");
    send(32'h7F800000, 32'hFF800000, 1'b0, 1'b0, "R7 inf+-inf");
    send(32'hFF800000, 32'h3F800000, 1'b0, 1'b1, "R7 -inf+1");
    send(32'h3F800000, 32'hFF800000, 1'b1, 1'b0, "R7 1-(-inf)");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 1'b0, "R8 ovf nearest");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 1'b1, "R8 ovf tozero");
    send(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 1'b1, "R8 neg ovf tozero");
    send(32'h7F7FFFFF, 32'h73000000, 1'b0, 1'b0, "R8 round to ovf");
    send(32'h3F800000, 32'h3F800000, 1'b1, 1'b0, "R9 x-x nearest");
    send(32'hBF800000, 32'h3F800000, 1'b0, 1'b1, "R9 -x+x tozero");
    send(32'h80000000, 32'h80000000, 1'b0, 1'b0, "R9 -0+-0");
    send(32'h80000000, 32'h00000000, 1'b1, 1'b1, "R9 -0-+0");
    send(32'h00000000, 32'h80000000, 1'b0, 1'b0, "R9 +0+-0");
    idle();
    repeat (5) @(negedge clk);

    // random traffic with gaps
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      logic op, rm;
      if ($urandom_range(0, 4) == 0) idle();
      a = pickOperand($urandom);
      b = pickOperand(a);
      op = 1'($urandom);
      rm = 1'($urandom);
      send(a, b, op, rm, rm ? "R2 random" : "R1 random");
    end
    idle();
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, "R10 drained", 32'(expQ.size()), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule